// File: doc/BRIEF.md
# SPI Master Shift Engine

This block is the serial core of an SPI master. It takes one parallel word at a time, shifts it out on MOSI while capturing MISO, and hands the captured word back in parallel. The frame length is programmable from 1 to 32 bits. Clock polarity, sampling phase, bit order and the MOSI level between frames are all programmable. A 16-bit reload value sets the serial clock rate. The transmitter and receiver can each be switched off, which gives transmit-only, receive-only and full-duplex operation.

In receive-only operation nothing is transmitted. Frames run only while a byte counter is non-zero. The counter is loaded through a request strobe and counts down by the bytes each frame completes. Every received word is reported together with the number of bytes in it that hold data. Word supply and word pickup use a simple handshake. A missing transmit word and an unread receive word each raise a one-cycle error pulse.

Top module: `spi_shift_engine`

## Requirements
- R1: A frame carries n = `cfg_len_m1` + 1 bits (1 to 32) and shows exactly n SCLK periods, which is 2n level changes. `busy` is high from the cycle after the frame is accepted until its last SCLK edge.
- R2: Each SCLK half period lasts `cfg_reload` + 1 clock cycles. The first edge also comes `cfg_reload` + 1 cycles after the frame is accepted.
- R3: SCLK rests at `cfg_cpol`. With `cfg_ph` = 1 (CPHA 0), MISO is sampled on the leading edges and MOSI changes on the trailing edges. With `cfg_ph` = 0 (CPHA 1), MISO is sampled on the trailing edges and MOSI changes on leading edges after the first.
- R4: Only bits n-1..0 of `tx_word` are sent. With `cfg_msb_first` = 1, bit n-1 is sent first. With `cfg_msb_first` = 0, bit 0 is sent first.
- R5: MOSI equals `cfg_idle` whenever no frame is running, and for the whole frame when the transmitter is off.
- R6: A received word holds its n bits in `rx_word[n-1:0]`, with zeros above, in the bit order set by `cfg_msb_first`. `rx_bytes` is ceil(n/8), from 1 to 4.
- R7: With the transmitter off and the receiver on, a frame starts only while `rx_todo` is non-zero. A `rx_req_we` strobe loads `rx_req_cnt` only when `rx_todo` is zero and is ignored otherwise. Each frame subtracts ceil(n/8) from `rx_todo`, stopping at zero.
- R8: `tx_ready` pulses for one cycle when a word is accepted, and never while a frame runs. `tx_valid` is ignored while the transmitter is off. With both directions off, no frame starts.
- R9: In full duplex, if `tx_valid` is low in the cycle of a frame's last edge, `tx_underflow` pulses in the next cycle.
- R10: A finished receive word sets `rx_valid`, and `rx_take` clears it. If a word finishes while `rx_valid` is still set and `rx_take` is low, the word is replaced and `rx_overflow` pulses in the next cycle.
- R11: After reset the engine is idle: `busy` and `rx_valid` are low, `rx_todo` is zero and SCLK sits at `cfg_cpol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_len_m1 | input | 5 | Frame length minus one |
| cfg_cpol | input | 1 | SCLK idle level |
| cfg_ph | input | 1 | Phase bit (1: sample on leading edge) |
| cfg_msb_first | input | 1 | Bit order, 1 = MSB first |
| cfg_idle | input | 1 | MOSI level when not transmitting |
| cfg_tx_off | input | 1 | Transmitter off |
| cfg_rx_off | input | 1 | Receiver off |
| cfg_reload | input | 16 | Half-period reload value |
| tx_word | input | 32 | Word to send |
| tx_valid | input | 1 | `tx_word` is available |
| tx_ready | output | 1 | Word accepted this cycle |
| rx_req_we | input | 1 | Load strobe for the receive byte count |
| rx_req_cnt | input | 16 | Receive byte count to load |
| rx_todo | output | 16 | Receive bytes still to do |
| rx_word | output | 32 | Last received word |
| rx_bytes | output | 3 | Valid bytes in `rx_word` |
| rx_valid | output | 1 | `rx_word` is unread |
| rx_take | input | 1 | Consume `rx_word` |
| busy | output | 1 | A frame is being shifted |
| tx_underflow | output | 1 | Full-duplex frame ended with no next word |
| rx_overflow | output | 1 | Unread receive word was replaced |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The assertions assume that the configuration inputs change only while `busy` is low. The engine latches most settings at frame start, but SCLK and MOSI follow the live polarity and idle inputs between frames. The stimulus changes configuration only after the engine has gone idle and its word queue has drained. It also writes receive requests only outside frames or while `rx_todo` is non-zero. This keeps the condition that the byte counter cannot rise during a receive-only frame. MISO changes away from the clock edge, so every sampled bit is well defined.

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int WORD_W = 32,
  parameter int BR_W   = 16,
  parameter int CNT_W  = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [$clog2(WORD_W)-1:0] cfg_len_m1,
  input  logic                      cfg_cpol,
  input  logic                      cfg_ph,
  input  logic                      cfg_msb_first,
  input  logic                      cfg_idle,
  input  logic                      cfg_tx_off,
  input  logic                      cfg_rx_off,
  input  logic [BR_W-1:0]           cfg_reload,
  input  logic [WORD_W-1:0]         tx_word,
  input  logic                      tx_valid,
  output logic                      tx_ready,
  input  logic                      rx_req_we,
  input  logic [CNT_W-1:0]          rx_req_cnt,
  output logic [CNT_W-1:0]          rx_todo,
  output logic [WORD_W-1:0]         rx_word,
  output logic [$clog2(WORD_W)-3:0] rx_bytes,
  output logic                      rx_valid,
  input  logic                      rx_take,
  output logic                      busy,
  output logic                      tx_underflow,
  output logic                      rx_overflow,
  output logic                      sclk,
  output logic                      mosi,
  input  logic                      miso
);
  localparam int LEN_W  = $clog2(WORD_W);
  localparam int TICK_W = LEN_W + 1;
  localparam int BYTE_W = LEN_W - 2;

  logic [BR_W-1:0]   div_q, lreload_q;
  logic [TICK_W-1:0] tick_q;
  logic [LEN_W-1:0]  llen_q;
  logic              lpol_q, lph_q, lmsb_q, ltxoff_q, lrxoff_q;
  logic [WORD_W-1:0] txw_q, rxsh_q, rx_next;

  wire tick_now = busy && (div_q == '0);
  wire fin      = tick_now && (tick_q == {llen_q, 1'b1});
  wire start    = !busy && ((!cfg_tx_off && tx_valid) ||
                            (cfg_tx_off && !cfg_rx_off && (rx_todo != '0)));
  wire sample   = tick_now && !lrxoff_q && (tick_q[0] != lph_q);

  wire [TICK_W-1:0] tick_m1   = tick_q - 1'b1;
  wire [LEN_W-1:0]  samp_step = tick_q[TICK_W-1:1];
  wire [LEN_W-1:0]  out_step  = (lph_q || tick_q == '0) ? tick_q[TICK_W-1:1]
                                                        : tick_m1[TICK_W-1:1];
  wire [LEN_W-1:0]  out_pos   = lmsb_q ? llen_q - out_step  : out_step;
  wire [LEN_W-1:0]  samp_pos  = lmsb_q ? llen_q - samp_step : samp_step;
  wire [BYTE_W-1:0] frame_bytes = BYTE_W'(llen_q >> 3) + 1'b1;
  wire [CNT_W-1:0]  fb_wide     = CNT_W'(frame_bytes);

  assign tx_ready = start && !cfg_tx_off;
  assign sclk     = busy ? (lpol_q ^ tick_q[0]) : cfg_cpol;
  assign mosi     = (busy && !ltxoff_q) ? txw_q[out_pos] : cfg_idle;

  always_comb begin
    rx_next = rxsh_q;
    if (sample) rx_next[samp_pos] = miso;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy         <= 1'b0;
      div_q        <= '0;
      lreload_q    <= '0;
      tick_q       <= '0;
      llen_q       <= '0;
      lpol_q       <= 1'b0;
      lph_q        <= 1'b0;
      lmsb_q       <= 1'b0;
      ltxoff_q     <= 1'b0;
      lrxoff_q     <= 1'b0;
      txw_q        <= '0;
      rxsh_q       <= '0;
      rx_word      <= '0;
      rx_bytes     <= '0;
      rx_valid     <= 1'b0;
      rx_todo      <= '0;
      tx_underflow <= 1'b0;
      rx_overflow  <= 1'b0;
    end else begin
      tx_underflow <= 1'b0;
      rx_overflow  <= 1'b0;
      if (start) begin
        busy      <= 1'b1;
        div_q     <= cfg_reload;
        lreload_q <= cfg_reload;
        tick_q    <= '0;
        llen_q    <= cfg_len_m1;
        lpol_q    <= cfg_cpol;
        lph_q     <= cfg_ph;
        lmsb_q    <= cfg_msb_first;
        ltxoff_q  <= cfg_tx_off;
        lrxoff_q  <= cfg_rx_off;
        txw_q     <= cfg_tx_off ? '0 : tx_word;
        rxsh_q    <= '0;
      end else if (busy) begin
        rxsh_q <= rx_next;
        if (tick_now) begin
          div_q  <= lreload_q;
          tick_q <= tick_q + 1'b1;
        end else begin
          div_q <= div_q - 1'b1;
        end
        if (fin) begin
          busy <= 1'b0;
          if (!ltxoff_q && !lrxoff_q && !tx_valid) tx_underflow <= 1'b1;
        end
      end

      if (fin && !lrxoff_q) begin
        rx_valid    <= 1'b1;
        rx_word     <= rx_next;
        rx_bytes    <= frame_bytes;
        rx_overflow <= rx_valid && !rx_take;
      end else if (rx_take) begin
        rx_valid <= 1'b0;
      end

      if (fin && ltxoff_q)
        rx_todo <= (rx_todo > fb_wide) ? rx_todo - fb_wide : '0;
      else if (rx_req_we && rx_todo == '0)
        rx_todo <= rx_req_cnt;
    end
  end

  assert_accept_starts_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |=> busy);
  assert_sclk_holds_between_ticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && div_q != '0) |=> $stable(sclk));
  assert_underflow_after_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_underflow |-> (!busy && $past(busy)));
  assert_overflow_keeps_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overflow |-> rx_valid);
  assert_todo_never_rises_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && ltxoff_q) |-> (rx_todo <= $past(rx_todo)));
  assert_byte_count_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (rx_bytes != '0 && int'(rx_bytes) <= WORD_W / 8));
endmodule

// File: tb/spi_shift_engine_bench.sv
module spi_shift_engine_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [4:0]  cfg_len_m1 = 5'd7;
  logic        cfg_cpol = 0, cfg_ph = 1, cfg_msb_first = 1, cfg_idle = 0;
  logic        cfg_tx_off = 0, cfg_rx_off = 0;
  logic [15:0] cfg_reload = 16'd1;
  logic [31:0] tx_word = '0;
  logic        tx_valid = 0;
  logic        tx_ready;
  logic        rx_req_we = 0;
  logic [15:0] rx_req_cnt = '0;
  logic [15:0] rx_todo;
  logic [31:0] rx_word;
  logic [2:0]  rx_bytes;
  logic        rx_valid, rx_take = 0, busy, tx_underflow, rx_overflow, sclk, mosi;
  logic        miso = 0;

  spi_shift_engine u_spi_shift_engine (
    .clk(clk), .rst_n(rst_n), .cfg_len_m1(cfg_len_m1), .cfg_cpol(cfg_cpol),
    .cfg_ph(cfg_ph), .cfg_msb_first(cfg_msb_first), .cfg_idle(cfg_idle),
    .cfg_tx_off(cfg_tx_off), .cfg_rx_off(cfg_rx_off), .cfg_reload(cfg_reload),
    .tx_word(tx_word), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_req_we(rx_req_we), .rx_req_cnt(rx_req_cnt), .rx_todo(rx_todo),
    .rx_word(rx_word), .rx_bytes(rx_bytes), .rx_valid(rx_valid), .rx_take(rx_take),
    .busy(busy), .tx_underflow(tx_underflow), .rx_overflow(rx_overflow),
    .sclk(sclk), .mosi(mosi), .miso(miso));

  int checks = 0, fails = 0, cyc = 0;
  bit auto_take = 1, comparing = 0;
  logic [31:0] txq[$];
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // driver: inputs change shortly after the falling edge
  always @(negedge clk) begin
    #1;
    tx_valid <= (txq.size() > 0);
    tx_word  <= (txq.size() > 0) ? txq[0] : 32'h0;
    rx_take  <= auto_take;
    lfsr     <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    miso     <= lfsr[0];
  end

  // behavioural reference
  int m_busy, m_div, m_edge, m_n, m_reload, m_todo, m_bytes;
  bit m_pol, m_ph, m_msb, m_txoff, m_rxoff, m_rxv, m_ovf, m_unf;
  logic [31:0] m_tx, m_rx, m_rxw;

  function automatic int bitpos(input int s);
    return m_msb ? (m_n - 1 - s) : s;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_div = 0; m_edge = 0; m_n = 1; m_reload = 0; m_todo = 0;
      m_bytes = 0; m_rxv = 0; m_ovf = 0; m_unf = 0; m_rxw = 0; m_tx = 0; m_rx = 0;
      m_pol = 0; m_ph = 0; m_msb = 0; m_txoff = 0; m_rxoff = 0;
    end else begin
      bit ended, took_req;
      int todo_before;
      ended = 0; m_ovf = 0; m_unf = 0;
      todo_before = m_todo;
      took_req = rx_req_we && todo_before == 0;
      if (m_busy != 0) begin
        if (m_div == 0) begin
          if (!m_rxoff && ((m_edge % 2 == 0) == m_ph)) m_rx[bitpos(m_edge / 2)] = miso;
          if (m_edge == 2 * m_n - 1) begin
            ended = 1; m_busy = 0;
            if (!m_txoff && !m_rxoff && !tx_valid) m_unf = 1;
            if (!m_rxoff) begin
              m_ovf = m_rxv && !rx_take;
              m_rxv = 1; m_rxw = m_rx; m_bytes = (m_n + 7) / 8;
            end
            if (m_txoff) m_todo = (m_todo > (m_n + 7) / 8) ? m_todo - (m_n + 7) / 8 : 0;
          end
          m_edge++; m_div = m_reload;
        end else m_div--;
      end else if ((!cfg_tx_off && tx_valid) || (cfg_tx_off && !cfg_rx_off && m_todo > 0)) begin
        m_busy = 1; m_div = cfg_reload; m_reload = cfg_reload; m_edge = 0;
        m_n = cfg_len_m1 + 1; m_pol = cfg_cpol; m_ph = cfg_ph; m_msb = cfg_msb_first;
        m_txoff = cfg_tx_off; m_rxoff = cfg_rx_off; m_rx = 0; m_tx = 0;
        if (!cfg_tx_off) begin m_tx = tx_word; void'(txq.pop_front()); end
      end
      if (!(ended && !m_rxoff) && rx_take) m_rxv = 0;
      if (!ended && took_req) m_todo = rx_req_cnt;
    end
  end

  // comparison away from the edges, plus frame shape measurements
  bit p_sclk = 0, p_busy = 0;
  int toggles = 0, last_t = -1, unf_seen = 0, ovf_seen = 0;
  always @(negedge clk) begin
    #2;
    cyc++;
    if (comparing) begin
      bit e_sclk, e_mosi, e_ready;
      int step;
      e_sclk = (m_busy != 0) ? (m_pol ^ m_edge[0]) : cfg_cpol;
      if (m_busy != 0 && !m_txoff) begin
        step = m_ph ? m_edge / 2 : (m_edge == 0 ? 0 : (m_edge - 1) / 2);
        e_mosi = m_tx[bitpos(step)];
      end else e_mosi = cfg_idle;
      e_ready = (m_busy == 0) && !cfg_tx_off && tx_valid;
      chk(busy == (m_busy != 0), "R11", "busy", busy, m_busy);
      chk(sclk == e_sclk, "R3", "sclk", sclk, e_sclk);
      chk(mosi == e_mosi, "R4", "mosi", mosi, e_mosi);
      chk(tx_ready == e_ready, "R8", "tx_ready", tx_ready, e_ready);
      chk(rx_valid == m_rxv, "R10", "rx_valid", rx_valid, m_rxv);
      if (m_rxv) begin
        chk(rx_word == m_rxw, "R6", "rx_word", rx_word, m_rxw);
        chk(rx_bytes == 3'(m_bytes), "R6", "rx_bytes", rx_bytes, m_bytes);
      end
      chk(rx_todo == 16'(m_todo), "R7", "rx_todo", rx_todo, m_todo);
      chk(tx_underflow == m_unf, "R9", "tx_underflow", tx_underflow, m_unf);
      chk(rx_overflow == m_ovf, "R10", "rx_overflow", rx_overflow, m_ovf);
      if (tx_underflow) unf_seen++;
      if (rx_overflow) ovf_seen++;
      if (busy && !p_busy) begin toggles = 0; last_t = cyc; end
      if ((busy || p_busy) && sclk != p_sclk) begin
        toggles++;
        chk(cyc - last_t == cfg_reload + 1, "R2", "half period", cyc - last_t, cfg_reload + 1);
        last_t = cyc;
      end
      if (!busy && p_busy)
        chk(toggles == 2 * (cfg_len_m1 + 1), "R1", "sclk edges per frame", toggles,
            2 * (cfg_len_m1 + 1));
    end
    p_sclk = sclk; p_busy = busy;
  end

  task automatic setup(input int len, input bit pol, input bit ph, input bit msb,
                       input bit idle, input bit txoff, input bit rxoff, input int rl);
    @(negedge clk);
    cfg_len_m1 = 5'(len - 1); cfg_cpol = pol; cfg_ph = ph; cfg_msb_first = msb;
    cfg_idle = idle; cfg_tx_off = txoff; cfg_rx_off = rxoff; cfg_reload = 16'(rl);
  endtask

  task automatic drain();
    int quiet;
    quiet = 0;
    while (quiet < 4) begin
      @(negedge clk);
      if (!busy && txq.size() == 0 && (!cfg_tx_off || cfg_rx_off || rx_todo == 0)) quiet++;
      else quiet = 0;
    end
  endtask

  task automatic req(input int n);
    @(negedge clk); rx_req_we = 1; rx_req_cnt = 16'(n);
    @(negedge clk); rx_req_we = 0;
  endtask

  initial begin
    int seen;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #3;
    chk(!busy && !rx_valid, "R11", "reset busy/rx_valid", {busy, rx_valid}, 0);
    chk(rx_todo == 0, "R11", "reset rx_todo", rx_todo, 0);
    chk(sclk == cfg_cpol && mosi == cfg_idle, "R5", "reset sclk/mosi", {sclk, mosi}, {cfg_cpol, cfg_idle});
    comparing = 1;

    setup(8, 0, 1, 1, 0, 0, 0, 1);      // mode 0, MSB first
    txq.push_back(32'hA5); txq.push_back(32'h3C); txq.push_back(32'hFFFF_FF01);
    drain();
    setup(13, 1, 0, 0, 1, 0, 0, 0);     // mode 3, LSB first
    txq.push_back(32'h1ABC); txq.push_back(32'h0F0F);
    drain();
    setup(32, 0, 0, 1, 0, 0, 0, 2);     // mode 1, full word
    txq.push_back(32'hDEAD_BEEF);
    drain();
    setup(1, 1, 1, 0, 1, 0, 0, 3);      // mode 2, single bit
    txq.push_back(32'h1); txq.push_back(32'h0);
    drain();
    setup(20, 0, 1, 0, 1, 0, 1, 0);     // transmit only
    txq.push_back(32'h0F_1234);
    drain();

    unf_seen = 0;                       // R9: queue runs dry in full duplex
    setup(8, 0, 1, 1, 0, 0, 0, 0);
    txq.push_back(32'h11); txq.push_back(32'h22);
    drain();
    chk(unf_seen > 0, "R9", "underflow pulses", unf_seen, 1);

    ovf_seen = 0;                       // R10: words left unread
    setup(9, 0, 1, 1, 0, 0, 0, 0);
    auto_take = 0;
    txq.push_back(32'h155); txq.push_back(32'h0AA);
    drain();
    chk(ovf_seen > 0 && rx_valid, "R10", "overflow pulses", ovf_seen, 1);
    auto_take = 1;
    repeat (3) @(negedge clk);
    chk(!rx_valid, "R10", "rx_valid after take", rx_valid, 0);

    setup(16, 1, 0, 1, 1, 1, 0, 1);     // R7: receive only, 5 bytes in 2-byte frames
    txq.push_back(32'h5555);
    repeat (6) @(negedge clk);
    chk(!busy && txq.size() == 1, "R7", "no frame without request", busy, 0);
    req(5);
    repeat (4) @(negedge clk);
    req(9);                             // ignored while rx_todo is non-zero
    seen = 0;
    while (rx_todo != 0 || busy) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(rx_todo == 0 && !busy, "R7", "todo exhausted", rx_todo, 0);
    chk(txq.size() == 1, "R8", "tx_valid ignored with transmitter off", txq.size(), 1);

    setup(8, 0, 1, 1, 0, 1, 1, 0);      // both directions off
    repeat (20) @(negedge clk);
    chk(!busy && txq.size() == 1, "R8", "no frame with both off", busy, 0);
    setup(24, 1, 1, 1, 0, 0, 0, 1);     // full duplex sends the held word
    txq.push_back(32'h00C0_FFEE);
    drain();
    chk(txq.size() == 0, "R8", "held words sent", txq.size(), 0);

    comparing = 0;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule